// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Engine

This block pairs a byte-wide working memory with a nonvolatile-style shadow array of the same depth. By default each array holds 8192 bytes. The host reads and writes the working memory through a simple synchronous port with enable, write and output-enable controls.

A one-cycle store pulse copies the whole working memory into the shadow. The copy starts with an erase pass that fills every shadow byte with 0xFF and then runs a program pass that copies the data across. A one-cycle recall pulse copies the shadow back into the working memory.

While a transfer runs, the busy output is high, host accesses are locked out and read data is forced to zero. Both arrays are modelled as single-port synchronous RAMs. The transfer engine walks addresses one per clock and uses a one-stage pipeline to carry each byte from the source array to the destination array.

Top module: `shadow_sram_engine`

## Requirements
- R1: When idle, a host write (en_i=1, we_i=1) stores wdata_i at addr_i on the next rising clock edge.
- R2: When idle, a host read (en_i=1, oe_i=1, we_i=0) presents the addressed byte on rdata_o after the next rising edge, and that value holds while no further read is issued and oe_i stays 1.
- R3: rdata_o is 0 whenever oe_i is 0 or busy_o is 1, including during reset.
- R4: A store pulse accepted while idle raises busy_o on the next edge, and busy_o stays high for exactly 2*DEPTH+1 cycles.
- R5: A store first writes 0xFF to every shadow byte and then programs every shadow byte with the working data. Afterwards the shadow holds the working data and no byte is left at 0xFF by the erase pass.
- R6: A recall pulse accepted while idle keeps busy_o high for exactly DEPTH+1 cycles, after which the working memory equals the shadow contents.
- R7: Store or recall pulses that arrive while busy_o is 1 are ignored: they neither lengthen the transfer nor start a second one.
- R8: Host writes and reads issued while busy_o is 1 have no effect on the working memory.
- R9: A host write in the same cycle as an accepted store pulse is performed, and the stored image includes it.
- R10: When store and recall pulse in the same idle cycle, the store runs and the recall is dropped.
- R11: Each transfer phase visits addresses 0 to DEPTH-1 in ascending order, one address per clock.
- R12: After a transfer completes, host reads and writes behave as in R1 and R2 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Host access enable |
| we_i | input | 1 | Host write select |
| oe_i | input | 1 | Host output enable |
| addr_i | input | ADDR_W | Host byte address |
| wdata_i | input | DATA_W | Host write data |
| store_i | input | 1 | Store request pulse |
| recall_i | input | 1 | Recall request pulse |
| rdata_o | output | DATA_W | Read data, zero when gated |
| busy_o | output | 1 | Transfer in progress |

## Verification
Two events can land on the same clock edge. The first pair is a host write and a store request. The bench drives both in one cycle, then overwrites that byte and recalls the image, and expects the byte written in that cycle to come back. The second pair is a store request and a recall request. The bench pulses both together, counts the busy cycles against the store length, and then checks that a later recall returns the image saved by that store rather than any other.

// File: rtl/sse_pkg.sv
package sse_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ERASE  = 3'd1,
        PH_PROG   = 3'd2,
        PH_RECALL = 3'd3,
        PH_FLUSH  = 3'd4
    } phase_e;
endpackage

// File: rtl/sse_ram.sv
module sse_ram #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] dout_q;

    always_ff @(posedge clk_i) begin
        if (en_i && we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dout_q <= '0;
        end else if (en_i && !we_i) begin
            dout_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = dout_q;
endmodule

// File: rtl/sse_seq.sv
module sse_seq
    import sse_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              store_i,
    input  logic              recall_i,
    output phase_e            phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              pend_o,
    output logic [ADDR_W-1:0] pend_addr_o,
    output logic              to_work_o,
    output logic              busy_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic              pend;
        logic [ADDR_W-1:0] pend_addr;
        logic              to_work;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (store_i) begin
                    st_d.phase   = PH_ERASE;
                    st_d.addr    = '0;
                    st_d.to_work = 1'b0;
                end else if (recall_i) begin
                    st_d.phase   = PH_RECALL;
                    st_d.addr    = '0;
                    st_d.to_work = 1'b1;
                end
            end
            PH_ERASE: begin
                st_d.addr = st_q.addr + 1'b1;
                if (st_q.addr == LAST) begin
                    st_d.phase = PH_PROG;
                end
            end
            PH_PROG, PH_RECALL: begin
                st_d.pend      = 1'b1;
                st_d.pend_addr = st_q.addr;
                st_d.addr      = st_q.addr + 1'b1;
                if (st_q.addr == LAST) begin
                    st_d.phase = PH_FLUSH;
                end
            end
            PH_FLUSH: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, addr: '0, pend: 1'b0, pend_addr: '0, to_work: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o     = st_q.phase;
    assign addr_o      = st_q.addr;
    assign pend_o      = st_q.pend;
    assign pend_addr_o = st_q.pend_addr;
    assign to_work_o   = st_q.to_work;
    assign busy_o      = (st_q.phase != PH_IDLE);

    // R4
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(store_i || recall_i));

    // R5
    erase_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_PROG) |-> ($past(st_q.phase) == PH_ERASE || $past(st_q.phase) == PH_PROG));

    // R7
    recall_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_RECALL) |=> (st_q.phase == PH_RECALL || st_q.phase == PH_FLUSH));

    // R10
    store_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_IDLE && store_i && recall_i) |=> (st_q.phase == PH_ERASE));

    // R11
    addr_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.phase == PH_ERASE || st_q.phase == PH_PROG || st_q.phase == PH_RECALL)
         && st_q.addr != LAST) |=> (st_q.addr == ADDR_W'($past(st_q.addr) + 1'b1)));
endmodule

// File: rtl/shadow_sram_engine.sv
module shadow_sram_engine
    import sse_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              we_i,
    input  logic              oe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              store_i,
    input  logic              recall_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);
    phase_e            phase;
    logic [ADDR_W-1:0] seq_addr;
    logic              pend;
    logic [ADDR_W-1:0] pend_addr;
    logic              to_work;
    logic              busy;

    logic              work_en, work_we;
    logic [ADDR_W-1:0] work_addr;
    logic [DATA_W-1:0] work_wdata, work_dout;
    logic              shad_en, shad_we;
    logic [ADDR_W-1:0] shad_addr;
    logic [DATA_W-1:0] shad_wdata, shad_dout;

    sse_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .store_i    (store_i),
        .recall_i   (recall_i),
        .phase_o    (phase),
        .addr_o     (seq_addr),
        .pend_o     (pend),
        .pend_addr_o(pend_addr),
        .to_work_o  (to_work),
        .busy_o     (busy)
    );

    always_comb begin
        work_en    = 1'b0;
        work_we    = 1'b0;
        work_addr  = addr_i;
        work_wdata = wdata_i;
        shad_en    = 1'b0;
        shad_we    = 1'b0;
        shad_addr  = seq_addr;
        shad_wdata = '1;
        unique case (phase)
            PH_IDLE: begin
                work_en = en_i && (we_i || oe_i);
                work_we = en_i && we_i;
            end
            PH_ERASE: begin
                shad_en = 1'b1;
                shad_we = 1'b1;
            end
            PH_PROG: begin
                work_en   = 1'b1;
                work_addr = seq_addr;
            end
            PH_RECALL: begin
                shad_en = 1'b1;
            end
            default: ;
        endcase
        if (pend) begin
            if (to_work) begin
                work_en    = 1'b1;
                work_we    = 1'b1;
                work_addr  = pend_addr;
                work_wdata = shad_dout;
            end else begin
                shad_en    = 1'b1;
                shad_we    = 1'b1;
                shad_addr  = pend_addr;
                shad_wdata = work_dout;
            end
        end
    end

    sse_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) work_ram_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (work_en),
        .we_i   (work_we),
        .addr_i (work_addr),
        .wdata_i(work_wdata),
        .rdata_o(work_dout)
    );

    sse_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shad_ram_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (shad_en),
        .we_i   (shad_we),
        .addr_i (shad_addr),
        .wdata_i(shad_wdata),
        .rdata_o(shad_dout)
    );

    assign busy_o  = busy;
    assign rdata_o = (busy || !oe_i) ? '0 : work_dout;

    // R8
    host_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (work_we && busy) |-> (to_work && pend));

    // R5
    erase_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase == PH_ERASE) |-> (shad_we && shad_wdata == '1));
endmodule

// File: tb/shadow_sram_engine_tb.sv
`timescale 1ns/1ps
module shadow_sram_engine_tb_top;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en, we, oe, store, recall;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          busy;
    int            checks = 0;
    int            fails  = 0;

    always #2.5 clk = ~clk;

    shadow_sram_engine #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .we_i(we), .oe_i(oe),
        .addr_i(addr), .wdata_i(wdata), .store_i(store), .recall_i(recall),
        .rdata_o(rdata), .busy_o(busy)
    );

    function automatic logic [7:0] pat(int a, int k);
        return 8'((a * 7 + k * 29 + 5) & 255);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        en = 1'b0; we = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] v);
        @(negedge clk);
        en = 1'b1; we = 1'b0; oe = 1'b1; addr = AW'(a);
        @(negedge clk);
        en = 1'b0;
        v = rdata;
    endtask

    task automatic fill(int k);
        for (int a = 0; a < N; a++) wr(a, pat(a, k));
    endtask

    task automatic verify(int k, string req);
        logic [7:0] v;
        for (int a = 0; a < N; a++) begin
            rd(a, v);
            chk(req, v, pat(a, k));
        end
    endtask

    // Pulses store/recall, optionally with a host write in the same cycle,
    // optionally disturbing the block while busy; returns busy cycle count.
    task automatic run_op(bit s, bit r, bit cowr, int cw_a, logic [7:0] cw_d,
                          bit disturb, output int cnt);
        @(negedge clk);
        store = s; recall = r;
        if (cowr) begin
            en = 1'b1; we = 1'b1; addr = AW'(cw_a); wdata = cw_d;
        end
        @(negedge clk);
        store = 1'b0; recall = 1'b0; en = 1'b0; we = 1'b0;
        chk("R4 busy raised", busy, 1);
        cnt = 0;
        while (busy) begin
            cnt++;
            if (disturb) begin
                if (cnt == 3)  begin en = 1'b1; we = 1'b1; addr = 3; wdata = 8'h00; end
                if (cnt == 4)  begin en = 1'b0; we = 1'b0; end
                if (cnt == 10) begin en = 1'b1; we = 1'b0; oe = 1'b1; addr = 1; end
                if (cnt == 11) begin chk("R3 busy read", rdata, 0); en = 1'b0; end
                if (cnt == 20) recall = 1'b1;
                if (cnt == 21) recall = 1'b0;
                if (cnt == 30) store = 1'b1;
                if (cnt == 31) store = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt;
        rst_n = 1'b0; en = 1'b0; we = 1'b0; oe = 1'b0;
        store = 1'b0; recall = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R3 reset rdata", rdata, 0);
        chk("R4 reset busy", busy, 0);
        rst_n = 1'b1;
        oe = 1'b1;

        fill(0);
        verify(0, "R1");
        rd(7, v);
        @(negedge clk);
        chk("R2 hold", rdata, pat(7, 0));
        oe = 1'b0;
        #1;
        chk("R3 oe low", rdata, 0);
        oe = 1'b1;

        run_op(1'b1, 1'b0, 1'b0, 0, 8'h00, 1'b1, cnt);
        chk("R4 store length", cnt, 2 * N + 1);
        chk("R7 no extension", cnt, 2 * N + 1);
        verify(0, "R8");

        fill(1);
        run_op(1'b0, 1'b1, 1'b0, 0, 8'h00, 1'b0, cnt);
        chk("R6 recall length", cnt, N + 1);
        verify(0, "R5");

        wr(9, 8'h3C);
        rd(9, v);
        chk("R12 resumed", v, 8'h3C);
        wr(9, pat(9, 0));

        run_op(1'b1, 1'b0, 1'b1, 5, 8'hA5, 1'b0, cnt);
        chk("R4 store length", cnt, 2 * N + 1);
        wr(5, 8'h00);
        wr(6, 8'h00);
        run_op(1'b0, 1'b1, 1'b0, 0, 8'h00, 1'b0, cnt);
        rd(5, v);
        chk("R9 same-cycle write", v, 8'hA5);
        rd(6, v);
        chk("R9 neighbour", v, pat(6, 0));

        fill(2);
        run_op(1'b1, 1'b1, 1'b0, 0, 8'h00, 1'b0, cnt);
        chk("R10 store wins", cnt, 2 * N + 1);
        verify(2, "R10");
        fill(3);
        run_op(1'b0, 1'b1, 1'b0, 0, 8'h00, 1'b0, cnt);
        chk("R6 recall length", cnt, N + 1);
        verify(2, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule